// File: doc/BRIEF.md
# Recovery Retry Throttle

This block decides when each of several ports may start a recovery attempt (a reconnect or a restart), so that a port that keeps failing cannot flood the system with retries. A port signals that it needs recovery. The block then waits out a backoff delay, measured in pulses of a shared tick timebase, and only after that delay issues a one-cycle grant for that port. While the attempt runs, the port reports either a failure or a stable link. Each failure doubles the backoff, up to a fixed ceiling. A stable link puts the port into a cooldown, and during the cooldown further recovery requests from that port are ignored.

All ports share a programmable cap on attempts in progress, and a grant-rate limit allows at most one new grant per tick interval. When several ports are eligible at once, a rotating pointer picks the winner. A port that fails a set number of times in a row raises a box-level escalation flag. Higher-scope logic uses that flag to widen the recovery scope beyond the port. Each port also exposes a count of the grants it has received.

Top module: `recov_throttle`

## Requirements
- R1: During and immediately after reset, every grant and every escalate output is 0, and every reconnect count is 0.
- R2: When a port with no recovery pending sees `req` high, its first grant is issued only after `base_ticks` tick pulses. With `tick` held high, the grant is visible in the cycle after the `base_ticks`-th clock edge that follows the edge at which `req` was captured.
- R3: Each `fail` during an attempt re-arms the backoff at `base_ticks * 2^k`, where k is the number of consecutive failures, capped at MAX_EXP (default 3). The count of tick edges from the `fail` edge to the next grant equals that delay.
- R4: A `stable` during an attempt starts a cooldown of `cool_ticks` tick pulses. `req` is ignored for that time and for one more cycle. The next request then uses the base delay again, so with `tick` high the grant follows `cool_ticks + 2 + base_ticks` edges after the `stable` edge.
- R5: The number of ports with an attempt in progress never exceeds `max_active`.
- R6: A `stable` or `fail` on an active port frees its concurrency slot in the same cycle, so a waiting eligible port can be granted in that very cycle.
- R7: At most one grant is issued per cycle. Among eligible ports, the search starts at the port after the last one granted and wraps around.
- R8: After a grant, the next grant cannot occur before the next cycle in which `tick` is high. A grant in a tick cycle is allowed.
- R9: `escalate[i]` goes high on the ESC_FAILS-th (default 3) consecutive failure of port i and stays high until that port's cooldown ends.
- R10: The field `rc_count[i*CNT_W +: CNT_W]` increments by one on each grant to port i and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse for delays and rate limit |
| base_ticks | input | BASE_W | Base backoff delay in ticks |
| cool_ticks | input | COOL_W | Cooldown length in ticks |
| max_active | input | $clog2(N_PORTS+1) | Cap on attempts in progress |
| req | input | N_PORTS | Per-port recovery request |
| fail | input | N_PORTS | Per-port attempt failed |
| stable | input | N_PORTS | Per-port link stable |
| grant | output | N_PORTS | One-cycle grant to start an attempt |
| escalate | output | N_PORTS | Box-level escalation request |
| rc_count | output | N_PORTS*CNT_W | Per-port grant counts, port i at bits i*CNT_W |

## Verification
On every cycle, the assertions check that at most one grant is issued at a time, that attempts in progress stay within the cap, that a grant never comes early against the tick rate limit, that no grant follows a stable report immediately, and that each escalation rise comes from a failure. They also check that every grant advances its counter unless the counter is already saturated. The bench scenarios alone can show the exact backoff lengths and their doubling and saturation, the length of the cooldown and the reset of the backoff after it, the rotation order of the pointer, and the same-cycle release of a slot.

// File: rtl/recov_pkg.sv
// Shared types for the recovery throttle.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package recov_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_WAIT   = 2'd1,
        PS_ACTIVE = 2'd2,
        PS_COOL   = 2'd3
    } port_state_e;
endpackage

// File: rtl/recov_port.sv
// Per-port recovery sequencer: backoff timer, attempt tracking, cooldown,
// consecutive-failure escalation and grant counter.
// Assumes: grant_in is only asserted while elig is high; tick is a
// single-cycle timebase pulse.
module recov_port
    import recov_pkg::*;
#(
    parameter int BASE_W    = 4,
    parameter int COOL_W    = 8,
    parameter int MAX_EXP   = 3,
    parameter int ESC_FAILS = 3,
    parameter int CNT_W     = 8,
    parameter int TMR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BASE_W-1:0] base_ticks,
    input  logic [COOL_W-1:0] cool_ticks,
    input  logic              req,
    input  logic              fail,
    input  logic              stable,
    input  logic              grant_in,
    output logic              elig,
    output logic              busy,
    output logic              release_now,
    output logic              escalate,
    output logic [CNT_W-1:0]  rc_count
);
    localparam int EW  = $clog2(MAX_EXP + 1);
    localparam int FW  = $clog2(ESC_FAILS + 1);
    localparam int SHW = BASE_W + MAX_EXP;

    port_state_e      state;
    logic [TMR_W-1:0] timer;
    logic [EW-1:0]    bexp;
    logic [EW-1:0]    bexp_n;
    logic [FW-1:0]    fails;
    logic [FW-1:0]    fails_n;
    logic [SHW-1:0]   delay_n;

    // Next backoff exponent and failure count, both saturating.
    always_comb begin
        bexp_n  = (bexp == EW'(MAX_EXP)) ? bexp : bexp + EW'(1);
        fails_n = (fails == FW'(ESC_FAILS)) ? fails : fails + FW'(1);
        delay_n = SHW'(base_ticks) << bexp_n;
    end

    // Status seen by the arbiter and the slot accounting.
    always_comb begin
        elig        = (state == PS_WAIT) && (timer == '0);
        busy        = (state == PS_ACTIVE);
        release_now = busy && (stable || fail);
    end

    // Port sequencer with its timer, exponent and failure tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_IDLE;
            timer    <= '0;
            bexp     <= '0;
            fails    <= '0;
            escalate <= 1'b0;
            rc_count <= '0;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (req) begin
                        state <= PS_WAIT;
                        timer <= TMR_W'(base_ticks);
                    end
                end
                PS_WAIT: begin
                    if (timer == '0) begin
                        if (grant_in) begin
                            state <= PS_ACTIVE;
                            if (rc_count != '1) rc_count <= rc_count + CNT_W'(1);
                        end
                    end else if (tick) begin
                        timer <= timer - TMR_W'(1);
                    end
                end
                PS_ACTIVE: begin
                    if (stable) begin
                        state <= PS_COOL;
                        timer <= TMR_W'(cool_ticks);
                    end else if (fail) begin
                        state    <= PS_WAIT;
                        timer    <= TMR_W'(delay_n);
                        bexp     <= bexp_n;
                        fails    <= fails_n;
                        escalate <= escalate || (fails_n == FW'(ESC_FAILS));
                    end
                end
                default: begin
                    if (timer == '0) begin
                        state    <= PS_IDLE;
                        bexp     <= '0;
                        fails    <= '0;
                        escalate <= 1'b0;
                    end else if (tick) begin
                        timer <= timer - TMR_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/recov_rr_arb.sv
// Round-robin single-winner arbiter: the search starts at the port after
// the last winner and wraps around.
// Assumes: N >= 2; allow gates every grant in the current cycle.
module recov_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         allow,
    output logic [N-1:0] gnt
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;
    logic [PW-1:0] win;

    // Pick the first requester at or after the pointer.
    always_comb begin
        gnt = '0;
        win = '0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = (int'(ptr) + off) % N;
            if (allow && (gnt == '0) && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (gnt != '0) begin
            ptr <= (win == PW'(N - 1)) ? '0 : win + PW'(1);
        end
    end
endmodule

// File: rtl/recov_throttle.sv
// Recovery throttle top: per-port sequencers, shared concurrency cap with
// same-cycle slot release, one-grant-per-tick rate limit, round-robin pick.
// Assumes: max_active, base_ticks and cool_ticks change only while no
// recovery is pending.
module recov_throttle #(
    parameter int N_PORTS   = 4,
    parameter int BASE_W    = 4,
    parameter int COOL_W    = 8,
    parameter int MAX_EXP   = 3,
    parameter int ESC_FAILS = 3,
    parameter int CNT_W     = 8,
    parameter int AW        = $clog2(N_PORTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [BASE_W-1:0]        base_ticks,
    input  logic [COOL_W-1:0]        cool_ticks,
    input  logic [AW-1:0]            max_active,
    input  logic [N_PORTS-1:0]       req,
    input  logic [N_PORTS-1:0]       fail,
    input  logic [N_PORTS-1:0]       stable,
    output logic [N_PORTS-1:0]       grant,
    output logic [N_PORTS-1:0]       escalate,
    output logic [N_PORTS*CNT_W-1:0] rc_count
);
    localparam int SHW   = BASE_W + MAX_EXP;
    localparam int TMR_W = (SHW > COOL_W) ? SHW : COOL_W;

    logic [N_PORTS-1:0] elig;
    logic [N_PORTS-1:0] busy;
    logic [N_PORTS-1:0] rel;
    logic [AW-1:0]      active_cnt;
    logic [AW-1:0]      rel_cnt;
    logic               slot_free;
    logic               rate_used;
    logic               allow;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        recov_port #(
            .BASE_W(BASE_W), .COOL_W(COOL_W), .MAX_EXP(MAX_EXP),
            .ESC_FAILS(ESC_FAILS), .CNT_W(CNT_W), .TMR_W(TMR_W)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .base_ticks(base_ticks), .cool_ticks(cool_ticks),
            .req(req[i]), .fail(fail[i]), .stable(stable[i]),
            .grant_in(grant[i]), .elig(elig[i]), .busy(busy[i]),
            .release_now(rel[i]), .escalate(escalate[i]),
            .rc_count(rc_count[i*CNT_W +: CNT_W])
        );
    end

    // Slots in use after this cycle's releases, compared with the cap.
    always_comb begin
        active_cnt = '0;
        rel_cnt    = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            active_cnt = active_cnt + AW'(busy[i]);
            rel_cnt    = rel_cnt + AW'(rel[i]);
        end
        slot_free = (active_cnt - rel_cnt) < max_active;
        allow     = slot_free && (!rate_used || tick);
    end

    // Rate limiter: a grant uses up the current tick window.
    always_ff @(posedge clk) begin
        if (!rst_n)          rate_used <= 1'b0;
        else if (grant != 0) rate_used <= 1'b1;
        else if (tick)       rate_used <= 1'b0;
    end

    recov_rr_arb #(.N(N_PORTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(elig), .allow(allow), .gnt(grant)
    );
endmodule

// File: rtl/recov_throttle_chk.sv
// Property checker for the recovery throttle, bound into every instance.
// Assumes: max_active held constant while attempts are in progress.
module recov_throttle_chk #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 8,
    parameter int AW      = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic [AW-1:0]            max_active,
    input logic [N_PORTS-1:0]       fail,
    input logic [N_PORTS-1:0]       stable,
    input logic [N_PORTS-1:0]       grant,
    input logic [N_PORTS-1:0]       busy,
    input logic [N_PORTS-1:0]       escalate,
    input logic [N_PORTS*CNT_W-1:0] rc_count
);
    logic armed;

    // Tracks whether a grant has happened with no tick since.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (grant != 0) armed <= 1'b1;
        else if (tick)       armed <= 1'b0;
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_conc_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy) <= int'(max_active));

    p_rate_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 0) |-> (!armed || tick));

    for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
        p_no_grant_after_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stable[i] && busy[i]) |=> !grant[i]);

        p_grant_starts_attempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> busy[i]);

        p_esc_from_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(escalate[i]) |-> $past(fail[i] && busy[i] && !stable[i]));

        p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> ((rc_count[i*CNT_W +: CNT_W] == $past(rc_count[i*CNT_W +: CNT_W]) + CNT_W'(1))
                          || ($past(rc_count[i*CNT_W +: CNT_W]) == '1)));
    end
endmodule

bind recov_throttle recov_throttle_chk #(
    .N_PORTS(N_PORTS), .CNT_W(CNT_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .max_active(max_active),
    .fail(fail), .stable(stable), .grant(grant), .busy(busy),
    .escalate(escalate), .rc_count(rc_count)
);

// File: tb/tb_recov_throttle.sv
// Bench for the recovery throttle: directed timing cases and a seeded
// random phase checked against a bench-side occupancy model.
module tb_recov_throttle;
    localparam int N  = 4;
    localparam int CW = 8;
    localparam int MX = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic [3:0]    base_ticks = 4'd2;
    logic [7:0]    cool_ticks = 8'd5;
    logic [2:0]    max_active = 3'd4;
    logic [N-1:0]  req = '0, fail = '0, stable = '0;
    logic [N-1:0]  grant, escalate;
    logic [N*CW-1:0] rc_count;

    int checks = 0;
    int errors = 0;

    recov_throttle dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .base_ticks(base_ticks),
        .cool_ticks(cool_ticks), .max_active(max_active), .req(req),
        .fail(fail), .stable(stable), .grant(grant), .escalate(escalate),
        .rc_count(rc_count)
    );

    always #4 clk = ~clk;

    function automatic int backoff(input int base, input int k);
        return base << ((k > MX) ? MX : k);
    endfunction

    function automatic int rc_of(input int p);
        return int'(rc_count[p*CW +: CW]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse fail/stable (optionally), hold req, count edges to the grant.
    task automatic attempt(input int p, input bit f, input bit s, output int cnt);
        req[p] = 1'b1; fail[p] = f; stable[p] = s;
        @(posedge clk); @(negedge clk);
        fail[p] = 1'b0; stable[p] = 1'b0;
        cnt = 0;
        while (!grant[p] && cnt < 2000) begin
            @(posedge clk); cnt++; @(negedge clk);
        end
        req[p] = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic release_ports(input logic [N-1:0] m);
        stable = m;
        @(posedge clk); @(negedge clk);
        stable = '0;
        repeat (14) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        int tally [N];
        int start [N];
        bit act [N];
        bit armed;
        int ng;
        int gcount;
        bit gap_bad;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(grant == 0, "R1 grant in reset", int'(grant), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(grant == 0, "R1 grant after reset", int'(grant), 0);
        chk(escalate == 0, "R1 escalate after reset", int'(escalate), 0);
        chk(rc_count == 0, "R1 counts after reset", int'(rc_count), 0);

        // R2 / R3 / R9: backoff growth on port 0 with tick always high.
        attempt(0, 1'b0, 1'b0, cnt);
        chk(cnt == 2, "R2 first grant delay", cnt, 2);
        for (int k = 1; k <= 4; k++) begin
            attempt(0, 1'b1, 1'b0, cnt);
            chk(cnt == backoff(2, k), "R3 backoff after failure", cnt, backoff(2, k));
            if (k == 2) chk(escalate[0] == 1'b0, "R9 no escalate after 2 fails", int'(escalate[0]), 0);
            if (k == 3) chk(escalate[0] == 1'b1, "R9 escalate after 3 fails", int'(escalate[0]), 1);
        end
        // R4: cooldown ignores req, then base delay again.
        attempt(0, 1'b0, 1'b1, cnt);
        chk(cnt == 5 + 2 + 2, "R4 cooldown then base delay", cnt, 9);
        chk(escalate[0] == 1'b0, "R9 escalate cleared by cooldown", int'(escalate[0]), 0);
        chk(rc_of(0) == 6, "R10 grant count port 0", rc_of(0), 6);
        release_ports(4'b0001);

        // R5 / R6: cap of one, same-cycle handover.
        max_active = 3'd1;
        req[1] = 1'b1; req[2] = 1'b1;
        cnt = 0;
        #1;
        while (grant == 0 && cnt < 50) begin @(posedge clk); cnt++; @(negedge clk); #1; end
        chk(grant == 4'b0010, "R7 pointer after port 0", int'(grant), 2);
        @(posedge clk); @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            #1;
            chk(grant[2] == 1'b0, "R5 cap holds port 2", int'(grant[2]), 0);
            @(posedge clk); @(negedge clk);
        end
        stable[1] = 1'b1;
        #1;
        chk(grant[2] == 1'b1, "R6 same-cycle release", int'(grant[2]), 1);
        @(posedge clk); @(negedge clk);
        stable[1] = 1'b0; req = '0;
        release_ports(4'b0100);

        // R7: pointer is past port 2, so port 3 wins over port 0.
        max_active = 3'd4;
        req[0] = 1'b1; req[3] = 1'b1;
        cnt = 0;
        #1;
        while (grant == 0 && cnt < 50) begin @(posedge clk); cnt++; @(negedge clk); #1; end
        chk(grant == 4'b1000, "R7 rotation picks port 3", int'(grant), 8);
        @(posedge clk); @(negedge clk); #1;
        chk(grant == 4'b0001, "R7 rotation then port 0", int'(grant), 1);
        @(posedge clk); @(negedge clk);
        req = '0;
        release_ports(4'b1001);

        // R8: tick every fourth cycle, all ports eligible at once.
        base_ticks = 4'd0;
        req = '1;
        armed = 1'b0; gcount = 0; gap_bad = 1'b0;
        for (int c = 0; c < 40; c++) begin
            tick = (c % 4 == 3);
            #1;
            if (grant != 0) begin
                if (armed && !tick) gap_bad = 1'b1;
                armed = 1'b1; gcount++;
            end else if (tick) armed = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        chk(!gap_bad, "R8 one grant per tick window", int'(gap_bad), 0);
        chk(gcount == 4, "R8 all ports served", gcount, 4);
        req = '0; tick = 1'b1;
        release_ports(4'b1111);

        // Random phase with fixed seed.
        void'($urandom(32'd1234));
        max_active = 3'd2; cool_ticks = 8'd3;
        for (int p = 0; p < N; p++) begin tally[p] = 0; start[p] = rc_of(p); act[p] = 1'b0; end
        armed = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            tick = ($urandom % 2) == 0;
            base_ticks = 4'(c / 750);
            for (int p = 0; p < N; p++) begin
                req[p]    = ($urandom % 5) == 0;
                fail[p]   = ($urandom % 10) == 0;
                stable[p] = !fail[p] && (($urandom % 10) == 0);
            end
            #1;
            chk($countones(grant) <= 1, "R7 single grant", $countones(grant), 1);
            if (grant != 0) begin
                chk(!(armed && !tick), "R8 random rate", int'(armed), 0);
                armed = 1'b1;
            end else if (tick) armed = 1'b0;
            ng = 0;
            for (int p = 0; p < N; p++) begin
                if (grant[p]) begin
                    chk(!act[p], "R5 grant to idle port", int'(act[p]), 0);
                    tally[p]++;
                end
                act[p] = (act[p] && !(stable[p] || fail[p])) || grant[p];
                ng += int'(act[p]);
            end
            chk(ng <= 2, "R5 random occupancy", ng, 2);
            @(posedge clk); @(negedge clk);
        end
        req = '0; fail = '0; stable = '0;
        #1;
        for (int p = 0; p < N; p++) begin
            int e;
            e = start[p] + tally[p];
            if (e > 255) e = 255;
            chk(rc_of(p) == e, "R10 random grant count", rc_of(p), e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule